// File: doc/BRIEF.md
# Four-Channel DMA Register Bank with Interrupt Status

This block is the processor-side register bank of a four-channel DMA controller. A host reaches it through an 8-bit bus with a 5-bit register offset. Each channel has a 16-bit address register, a 16-bit word count and a control/status byte. The bank also holds one global priority/enable byte, an interrupt enable register and a chain configuration register. The register contents go out as flat buses to the channel sequencers. The sequencers report back through pulse inputs: transfer start, transfer done and chain completion. They can also load a whole new address and count into a channel in one cycle.

Reads have side effects. Reading a control byte clears that channel's done flag. Reading the interrupt register clears the sticky interrupt flag and the chain-completion flag. The chain-completion flag is not visible on its own: it is folded into the interrupt register readback, masked by the channel 0 interrupt enable.

A two-state machine drives the interrupt output. IRQ_IDLE goes to IRQ_ACTIVE (transition *raise*) in the cycle after some channel has both its enable and its done flag set. IRQ_ACTIVE goes back to IRQ_IDLE (transition *drop*) in the cycle after no such channel remains. In all other cases each state holds.

Top module: `dmarf_top`

## Requirements
- R1: After reset every address and count register reads 0xFFFF, every control byte is 0x00, the priority, interrupt and chain registers read 0x00, and `irq` is low.
- R2: Offsets 0x00–0x0F select the per-channel registers, with channel = offset bits 3:2. Within a channel's group, offsets 0, 1, 2 and 3 are address high, address low, count high and count low. A byte write leaves the other byte unchanged.
- R3: A write to offset 0x10+n replaces only bits 3:0 of channel n's control byte. Bits 7:6 keep their value and bits 5:4 always read 0.
- R4: A read of offset 0x10+n returns all 8 bits of control byte n and then clears bit 7 (done). When `seq_done[n]` pulses in the same cycle, done stays set.
- R5: A `seq_start[n]` pulse sets control bit 6 (busy) and clears bit 7. A `seq_done[n]` pulse sets bit 7 and clears bit 6. Done wins when both arrive in the same cycle.
- R6: Offset 0x14 is the priority register. Writes are ANDed with 0x8F, the value reads back unchanged, and it appears on `prio_out` (bit 0 = global transfer enable).
- R7: At offset 0x15, writes change only bits 3:0, the per-channel interrupt enables. Bit 7 is a sticky flag. It is set one cycle after any channel has both its enable and its done bit set, and it is never written by the bus.
- R8: A read of 0x15 returns {flag, 3'b000, enables AND {3'b000, chain_flag}}. It then clears the flag and chain_flag, unless a set condition for that flag is present in the same cycle.
- R9: Offset 0x16 is the chain register. Writes update bits 3:0, which appear on `chain_cfg`. Reads return bits 3:0 with 0 above them. A `chain_done` pulse sets the hidden chain_flag.
- R10: `irq` rises one cycle after the request (some enabled channel done) becomes true and falls one cycle after it becomes false.
- R11: A `seq_load[n]` pulse replaces channel n's address and count with `seq_addr`/`seq_count` slice n in the next cycle. It takes priority over a bus write to that channel in the same cycle.
- R12: Reads of offsets 0x17–0x1F return 0xFF. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| seq_start | input | 4 | Per-channel transfer start pulse |
| seq_done | input | 4 | Per-channel transfer done pulse |
| seq_load | input | 4 | Per-channel address/count reload strobe |
| seq_addr | input | 64 | Reload addresses, channel n at bits 16n+15:16n |
| seq_count | input | 64 | Reload counts, channel n at bits 16n+15:16n |
| chain_done | input | 1 | Chain completion pulse |
| ch_addr | output | 64 | Current addresses, channel n at bits 16n+15:16n |
| ch_count | output | 64 | Current counts, channel n at bits 16n+15:16n |
| ch_ctl | output | 32 | Control bytes, channel n at bits 8n+7:8n |
| prio_out | output | 8 | Priority/enable register |
| chain_cfg | output | 4 | Chain configuration bits |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bound checker watches every cycle for the following:
- A done pulse sets the done bit and a start pulse sets the busy bit.
- A control read clears done unless a done pulse arrives in the same cycle.
- A control write keeps bits 7:6 and loads bits 3:0.
- A sequencer reload lands in the next cycle.
- `irq` tracks the enabled-done request with exactly one cycle of lag.

The directed scenarios show what a property cannot express compactly:
- the byte order inside each channel group;
- the masking of the priority register;
- the folded chain-flag readback and how reads clear it;
- the sticky interrupt flag surviving a read while its cause persists;
- unmapped offsets leaving every register untouched.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;

    localparam logic [4:0] OFS_CTL_BASE = 5'h10;
    localparam logic [4:0] OFS_PRIO     = 5'h14;
    localparam logic [4:0] OFS_IEN      = 5'h15;
    localparam logic [4:0] OFS_CHAIN    = 5'h16;

    localparam logic [7:0] PRIO_MASK     = 8'h8F;
    localparam logic [7:0] UNMAPPED_DATA = 8'hFF;
    localparam logic [REG_W-1:0] REG_RESET = 16'hFFFF;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/dmarf_chan_bank.sv
module dmarf_chan_bank
    import dmarf_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           ofs,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic [NCH-1:0]       ld,
    input  logic [NCH*REG_W-1:0] ld_addr,
    input  logic [NCH*REG_W-1:0] ld_count,
    output logic [NCH*REG_W-1:0] addr_o,
    output logic [NCH*REG_W-1:0] count_o,
    output logic [BYTE_W-1:0]    rd_byte
);
    localparam int CH_W = $clog2(NCH);

    logic [REG_W-1:0] addr_arr  [NCH];
    logic [REG_W-1:0] count_arr [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [REG_W-1:0] addr_q;
        logic [REG_W-1:0] count_q;
        logic             hit;

        assign hit = wr_en && (ofs[CH_W+1:2] == CH_W'(c));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q  <= REG_RESET;
                count_q <= REG_RESET;
            end else if (ld[c]) begin
                addr_q  <= ld_addr[c*REG_W +: REG_W];
                count_q <= ld_count[c*REG_W +: REG_W];
            end else if (hit) begin
                case (ofs[1:0])
                    2'd0: addr_q[15:8]  <= wdata;
                    2'd1: addr_q[7:0]   <= wdata;
                    2'd2: count_q[15:8] <= wdata;
                    default: count_q[7:0] <= wdata;
                endcase
            end
        end

        assign addr_o[c*REG_W +: REG_W]  = addr_q;
        assign count_o[c*REG_W +: REG_W] = count_q;
        assign addr_arr[c]  = addr_q;
        assign count_arr[c] = count_q;
    end

    logic [REG_W-1:0] sel_addr;
    logic [REG_W-1:0] sel_count;

    always_comb begin
        sel_addr  = addr_arr[ofs[CH_W+1:2]];
        sel_count = count_arr[ofs[CH_W+1:2]];
        case (ofs[1:0])
            2'd0: rd_byte = sel_addr[15:8];
            2'd1: rd_byte = sel_addr[7:0];
            2'd2: rd_byte = sel_count[15:8];
            default: rd_byte = sel_count[7:0];
        endcase
    end
endmodule

// File: rtl/dmarf_ctl_bank.sv
module dmarf_ctl_bank
    import dmarf_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        wr_sel,
    input  logic [3:0]            wdata_lo,
    input  logic [NCH-1:0]        rd_clr,
    input  logic [NCH-1:0]        start,
    input  logic [NCH-1:0]        done,
    output logic [NCH*BYTE_W-1:0] ctl_o,
    output logic [NCH-1:0]        done_vec
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic       done_q;
        logic       busy_q;
        logic [3:0] mode_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_q <= 1'b0;
                busy_q <= 1'b0;
                mode_q <= 4'h0;
            end else begin
                if (wr_sel[c]) mode_q <= wdata_lo;
                if (done[c]) begin
                    done_q <= 1'b1;
                    busy_q <= 1'b0;
                end else if (start[c]) begin
                    done_q <= 1'b0;
                    busy_q <= 1'b1;
                end else if (rd_clr[c]) begin
                    done_q <= 1'b0;
                end
            end
        end

        assign ctl_o[c*BYTE_W +: BYTE_W] = {done_q, busy_q, 2'b00, mode_q};
        assign done_vec[c] = done_q;
    end
endmodule

// File: rtl/dmarf_irq_fsm.sv
module dmarf_irq_fsm
    import dmarf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic irq
);
    irq_state_e state_q;
    irq_state_e state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (req)  state_n = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!req) state_n = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end
endmodule

// File: rtl/dmarf_top.sv
module dmarf_top
    import dmarf_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_wr,
    input  logic [4:0]            bus_addr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic [NCH-1:0]        seq_start,
    input  logic [NCH-1:0]        seq_done,
    input  logic [NCH-1:0]        seq_load,
    input  logic [NCH*REG_W-1:0]  seq_addr,
    input  logic [NCH*REG_W-1:0]  seq_count,
    input  logic                  chain_done,
    output logic [NCH*REG_W-1:0]  ch_addr,
    output logic [NCH*REG_W-1:0]  ch_count,
    output logic [NCH*BYTE_W-1:0] ch_ctl,
    output logic [BYTE_W-1:0]     prio_out,
    output logic [3:0]            chain_cfg,
    output logic                  irq
);
    logic bus_write;
    logic bus_read;
    assign bus_write = bus_en && bus_wr;
    assign bus_read  = bus_en && !bus_wr;

    // per-channel address / count registers
    logic [BYTE_W-1:0] chan_rd;

    dmarf_chan_bank #(.NCH(NCH)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_write && !bus_addr[4]),
        .ofs      (bus_addr[3:0]),
        .wdata    (bus_wdata),
        .ld       (seq_load),
        .ld_addr  (seq_addr),
        .ld_count (seq_count),
        .addr_o   (ch_addr),
        .count_o  (ch_count),
        .rd_byte  (chan_rd)
    );

    // control bytes
    logic [NCH-1:0] ctl_wr;
    logic [NCH-1:0] ctl_rd;
    logic [NCH-1:0] done_vec;

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign ctl_wr[c] = bus_write && (bus_addr == OFS_CTL_BASE + 5'(c));
        assign ctl_rd[c] = bus_read  && (bus_addr == OFS_CTL_BASE + 5'(c));
    end

    dmarf_ctl_bank #(.NCH(NCH)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (ctl_wr),
        .wdata_lo (bus_wdata[3:0]),
        .rd_clr   (ctl_rd),
        .start    (seq_start),
        .done     (seq_done),
        .ctl_o    (ch_ctl),
        .done_vec (done_vec)
    );

    // global registers
    logic [BYTE_W-1:0] prio_q;
    logic [NCH-1:0]    ien_q;
    logic              int_flag_q;
    logic [3:0]        chain_q;
    logic              chain_flag_q;
    logic              irq_req;
    logic              ien_read;

    assign irq_req  = |(ien_q & done_vec);
    assign ien_read = bus_read && (bus_addr == OFS_IEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q       <= '0;
            ien_q        <= '0;
            int_flag_q   <= 1'b0;
            chain_q      <= '0;
            chain_flag_q <= 1'b0;
        end else begin
            if (bus_write && bus_addr == OFS_PRIO)  prio_q  <= bus_wdata & PRIO_MASK;
            if (bus_write && bus_addr == OFS_IEN)   ien_q   <= bus_wdata[NCH-1:0];
            if (bus_write && bus_addr == OFS_CHAIN) chain_q <= bus_wdata[3:0];

            if (irq_req)       int_flag_q <= 1'b1;
            else if (ien_read) int_flag_q <= 1'b0;

            if (chain_done)    chain_flag_q <= 1'b1;
            else if (ien_read) chain_flag_q <= 1'b0;
        end
    end

    assign prio_out  = prio_q;
    assign chain_cfg = chain_q;

    // read data
    always_comb begin
        bus_rdata = UNMAPPED_DATA;
        if (!bus_addr[4]) begin
            bus_rdata = chan_rd;
        end else if (bus_addr[4:2] == 3'b100) begin
            bus_rdata = ch_ctl[bus_addr[1:0]*BYTE_W +: BYTE_W];
        end else begin
            case (bus_addr)
                OFS_PRIO:  bus_rdata = prio_q;
                OFS_IEN:   bus_rdata = {int_flag_q, 3'b000, ien_q & NCH'(chain_flag_q)};
                OFS_CHAIN: bus_rdata = {4'h0, chain_q};
                default:   bus_rdata = UNMAPPED_DATA;
            endcase
        end
    end

    dmarf_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_req),
        .irq   (irq)
    );
endmodule

// File: rtl/dmarf_checker.sv
module dmarf_checker #(
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [4:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [NCH-1:0]    seq_start,
    input logic [NCH-1:0]    seq_done,
    input logic [NCH-1:0]    seq_load,
    input logic [NCH*16-1:0] seq_addr,
    input logic [NCH*16-1:0] ch_addr,
    input logic [NCH*8-1:0]  ch_ctl,
    input logic [NCH-1:0]    ien,
    input logic              irq
);
    logic [NCH-1:0] done_bits;
    always_comb begin
        for (int c = 0; c < NCH; c++) done_bits[c] = ch_ctl[c*8+7];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
            seq_done[c] |=> (ch_ctl[c*8+7] && !ch_ctl[c*8+6]));

        a_r5_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_start[c] && !seq_done[c]) |=> (ch_ctl[c*8+6] && !ch_ctl[c*8+7]));

        a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_en && !bus_wr && bus_addr == 5'h10 + 5'(c) && !seq_done[c])
            |=> !ch_ctl[c*8+7]);

        a_r3_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_en && bus_wr && bus_addr == 5'h10 + 5'(c) && !seq_start[c] && !seq_done[c])
            |=> (ch_ctl[c*8+6 +: 2] == $past(ch_ctl[c*8+6 +: 2]))
                && (ch_ctl[c*8 +: 4] == $past(bus_wdata[3:0])));

        a_r11_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
            seq_load[c] |=> (ch_addr[c*16 +: 16] == $past(seq_addr[c*16 +: 16])));
    end

    a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ien & done_bits)) |=> irq);

    a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(ien & done_bits)) |=> !irq);
endmodule

bind dmarf_top dmarf_checker #(.NCH(NCH)) u_dmarf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .seq_start (seq_start),
    .seq_done  (seq_done),
    .seq_load  (seq_load),
    .seq_addr  (seq_addr),
    .ch_addr   (ch_addr),
    .ch_ctl    (ch_ctl),
    .ien       (ien_q),
    .irq       (irq)
);

// File: tb/tb_dmarf_top.sv
module tb_dmarf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  seq_start = '0;
    logic [3:0]  seq_done = '0;
    logic [3:0]  seq_load = '0;
    logic [63:0] seq_addr = '0;
    logic [63:0] seq_count = '0;
    logic        chain_done = 1'b0;
    logic [63:0] ch_addr;
    logic [63:0] ch_count;
    logic [31:0] ch_ctl;
    logic [7:0]  prio_out;
    logic [3:0]  chain_cfg;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dmarf_top dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_start(seq_start), .seq_done(seq_done), .seq_load(seq_load),
        .seq_addr(seq_addr), .seq_count(seq_count), .chain_done(chain_done),
        .ch_addr(ch_addr), .ch_count(ch_count), .ch_ctl(ch_ctl),
        .prio_out(prio_out), .chain_cfg(chain_cfg), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic pulse(input logic [3:0] st, input logic [3:0] dn, input logic cd);
        @(negedge clk);
        seq_start = st; seq_done = dn; chain_done = cd;
        @(negedge clk);
        seq_start = '0; seq_done = '0; chain_done = 1'b0;
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++) begin
            chk("R1 addr reset", ch_addr[c*16 +: 16], 16'hFFFF);
            chk("R1 count reset", ch_count[c*16 +: 16], 16'hFFFF);
        end
        chk("R1 ctl reset", ch_ctl, 32'h0);
        chk("R1 irq reset", irq, 0);
        chk("R1 prio reset", prio_out, 0);
        chk("R1 chain reset", chain_cfg, 0);
        rd_chk("R1 read 0x00", 5'h00, 8'hFF);
        rd_chk("R1 read 0x0B", 5'h0B, 8'hFF);
        rd_chk("R1 read 0x15", 5'h15, 8'h00);
    endtask

    task automatic t_chan_map;
        wr(5'h04, 8'h12); wr(5'h05, 8'h34); wr(5'h06, 8'h56); wr(5'h07, 8'h78);
        chk("R2 ch1 addr", ch_addr[31:16], 16'h1234);
        chk("R2 ch1 count", ch_count[31:16], 16'h5678);
        rd_chk("R2 read 0x05", 5'h05, 8'h34);
        rd_chk("R2 read 0x06", 5'h06, 8'h56);
        wr(5'h0C, 8'hAB);
        chk("R2 ch3 addr high only", ch_addr[63:48], 16'hABFF);
        chk("R2 ch3 count untouched", ch_count[63:48], 16'hFFFF);
        chk("R2 ch0 untouched", ch_addr[15:0], 16'hFFFF);
    endtask

    task automatic t_ctl;
        wr(5'h12, 8'hFF);
        chk("R3 write low nibble only", ch_ctl[23:16], 8'h0F);
        rd_chk("R3 readback", 5'h12, 8'h0F);
        pulse(4'b0100, 4'b0000, 1'b0);
        chk("R5 start sets busy", ch_ctl[23:16], 8'h4F);
        wr(5'h12, 8'h05);
        chk("R3 write keeps busy", ch_ctl[23:16], 8'h45);
        pulse(4'b0000, 4'b0100, 1'b0);
        chk("R5 done sets bit7", ch_ctl[23:16], 8'h85);
        rd_chk("R4 read full byte", 5'h12, 8'h85);
        chk("R4 read clears done", ch_ctl[23:16], 8'h05);
        rd_chk("R4 second read", 5'h12, 8'h05);
    endtask

    task automatic t_done_vs_read;
        logic [7:0] d;
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 5'h11; seq_done = 4'b0010;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0; seq_done = '0;
        chk("R4 read returns old", d, 8'h00);
        chk("R4 done wins over read clear", ch_ctl[15:8], 8'h80);
        rd_chk("R4 read done ch1", 5'h11, 8'h80);
        chk("R4 ch1 cleared", ch_ctl[15:8], 8'h00);
        pulse(4'b0001, 4'b0001, 1'b0);
        chk("R5 done wins over start", ch_ctl[7:0], 8'h80);
        rd_chk("R4 read ch0", 5'h10, 8'h80);
    endtask

    task automatic t_prio;
        wr(5'h14, 8'hFF);
        rd_chk("R6 masked readback", 5'h14, 8'h8F);
        chk("R6 prio_out", prio_out, 8'h8F);
        wr(5'h14, 8'h01);
        chk("R6 enable only", prio_out, 8'h01);
    endtask

    task automatic t_chain;
        wr(5'h16, 8'hFF);
        chk("R9 chain_cfg", chain_cfg, 4'hF);
        rd_chk("R9 chain readback", 5'h16, 8'h0F);
        wr(5'h15, 8'h01);
        rd_chk("R8 no chain flag", 5'h15, 8'h00);
        pulse(4'b0000, 4'b0000, 1'b1);
        rd_chk("R9 chain flag hidden in 0x16", 5'h16, 8'h0F);
        rd_chk("R8 chain flag folded", 5'h15, 8'h01);
        rd_chk("R8 chain flag cleared", 5'h15, 8'h00);
    endtask

    task automatic t_irq_mask;
        pulse(4'b0000, 4'b0010, 1'b0);
        @(negedge clk); @(negedge clk);
        chk("R7 disabled channel no irq", irq, 0);
        rd_chk("R7 flag not set", 5'h15, 8'h00);
        rd_chk("R4 clear ch1", 5'h11, 8'h80);
    endtask

    task automatic t_irq;
        wr(5'h15, 8'h0F);
        pulse(4'b0000, 4'b1000, 1'b0);
        chk("R10 irq lags one cycle", irq, 0);
        @(negedge clk);
        chk("R10 irq raised", irq, 1);
        rd_chk("R7 flag set", 5'h15, 8'h80);
        rd_chk("R8 flag survives while pending", 5'h15, 8'h80);
        rd_chk("R4 read ch3 done", 5'h13, 8'h80);
        chk("R10 irq still high", irq, 1);
        @(negedge clk);
        chk("R10 irq dropped", irq, 0);
        rd_chk("R7 flag sticky", 5'h15, 8'h80);
        rd_chk("R8 flag cleared", 5'h15, 8'h00);
        wr(5'h15, 8'h80);
        rd_chk("R7 bit7 not writable", 5'h15, 8'h00);
    endtask

    task automatic t_load;
        @(negedge clk);
        seq_load = 4'b0010;
        seq_addr[31:16] = 16'hBEEF;
        seq_count[31:16] = 16'h0042;
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 8'h00;
        @(negedge clk);
        seq_load = '0; bus_en = 1'b0; bus_wr = 1'b0;
        chk("R11 load beats write", ch_addr[31:16], 16'hBEEF);
        chk("R11 count loaded", ch_count[31:16], 16'h0042);
        rd_chk("R11 read count low", 5'h07, 8'h42);
        rd_chk("R11 read addr high", 5'h04, 8'hBE);
    endtask

    task automatic t_unmapped;
        logic [31:0] ctl_s;
        logic [63:0] addr_s;
        logic [63:0] cnt_s;
        logic [7:0]  prio_s;
        logic [3:0]  chain_s;
        rd_chk("R12 read 0x17", 5'h17, 8'hFF);
        rd_chk("R12 read 0x1F", 5'h1F, 8'hFF);
        ctl_s = ch_ctl; addr_s = ch_addr; cnt_s = ch_count;
        prio_s = prio_out; chain_s = chain_cfg;
        wr(5'h17, 8'h00); wr(5'h18, 8'h00); wr(5'h1F, 8'h00);
        chk("R12 ctl unchanged", ch_ctl, ctl_s);
        chk("R12 addr low half unchanged", addr_s[31:0], ch_addr[31:0]);
        chk("R12 addr high half unchanged", addr_s[63:32], ch_addr[63:32]);
        chk("R12 count unchanged", cnt_s[31:0], ch_count[31:0]);
        chk("R12 prio unchanged", prio_out, prio_s);
        chk("R12 chain unchanged", chain_cfg, chain_s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chan_map();
        t_ctl();
        t_done_vs_read();
        t_prio();
        t_chain();
        t_irq_mask();
        t_irq();
        t_load();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule